// File: doc/BRIEF.md
# Serial Register Slave for Oscillator Tuning

This block is a two-wire serial bus slave that owns a small register map for a digitally tuned oscillator controller. It runs on a fast system clock. It samples the bus clock and data lines through two-flop synchronizers and recognises start, repeated-start and stop conditions. It answers a fixed 7-bit device address and turns the first data byte of a write into a register pointer. After that it writes or reads consecutive registers, and the pointer advances after every byte. The data line is driven open drain: the block only pulls it low, through `sda_oe`.

The map holds a 15-bit two's-complement frequency-tune word and a compensation-hold bit, which are sent to the controller. It also holds a user copy of a 12-bit temperature. That copy is refreshed only while the master addresses the block for writing and sends a word address. A single multibyte read therefore returns a coherent temperature even while the live value keeps changing.

Top module: `tune_reg_i2c`

## Requirements
- R1: The block acknowledges only the address bytes 82h (write) and 83h (read), which carry the 7-bit address 1000001 followed by the direction bit. After any other address byte it drives nothing and changes no register until the next start or stop.
- R2: A falling data line while the clock is high is a start. A rising data line while the clock is high is a stop. A repeated start begins a new address phase. A stop releases the data line.
- R3: In a write, the first byte after the address loads the pointer. Each further byte is stored at the pointer, and the pointer then advances by one.
- R4: A read begins at the current pointer, which is the last value stored if no word address preceded the read. The pointer advances after every byte sent, and the data line is released once the master answers a byte with NACK.
- R5: Register 00h holds the hold bit in bit 7 and tune bits 14..8 in bits 6..0, with bit 6 as the sign. Register 01h holds tune bits 7..0. `tune_word` is {00h[6:0], 01h} and `comp_hold` is 00h[7]. Both registers reset to 00h.
- R6: Register 02h returns temperature bits 11..4. Register 03h returns temperature bits 3..0 in its upper nibble and zero in its lower nibble.
- R7: The user temperature copy resets to 190h (+25 degrees at 1/16 degree per LSB). It is loaded from `temp_live` when a matching write address is received and when a word address is received. Reads never reload it.
- R8: Writes to 02h, 03h and to addresses above 03h are acknowledged and have no effect. Addresses above 03h read as 00h.
- R9: `tune_strobe` is a single-cycle pulse issued when a byte is stored into 01h. The low tune byte never changes without that pulse.
- R10: The block pulls the data line low only while the synchronized bus clock is low. It holds its acknowledge through the high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| temp_live | input | 12 | Live temperature code from the sensor path |
| tune_word | output | 15 | Two's-complement frequency-tune word |
| comp_hold | output | 1 | Freezes the compensation update when 1 |
| tune_strobe | output | 1 | One-cycle pulse after the low tune byte is written |

## Verification
A wrong pointer or wrong write decode becomes visible on the next read-back byte, which is at most one bus transaction later. The same fault also appears on `tune_word` and `comp_hold` in the cycle after the byte is stored. A wrong bit count or a wrong acknowledge state shows up within one byte time: the ninth-clock acknowledge is missing or appears where it should not, or a read byte is shifted. A temperature copy that is loaded at the wrong moment returns mixed high and low parts inside a single multibyte read while the live value changes underneath it.

// File: rtl/tune_reg_i2c.sv
module tune_reg_i2c #(
  parameter logic [6:0]  DEV_ADDR = 7'b1000001,
  parameter int          TEMP_W   = 12,
  parameter logic [11:0] TEMP_RST = 12'h190
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [TEMP_W-1:0] temp_live,
  output logic [14:0]       tune_word,
  output logic              comp_hold,
  output logic              tune_strobe
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_PTR = 3'd2,
                         S_WR = 3'd3, S_RD = 3'd4;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q, scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  logic [2:0] state;
  logic [3:0] bitcnt;
  logic       ack_slot, mnack;
  logic [7:0] rx, tx, ptr, reg_ctl, reg_lo, rd_byte;
  logic [TEMP_W-1:0] snap;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign tune_word = {reg_ctl[6:0], reg_lo};
  assign comp_hold = reg_ctl[7];

  always_comb begin
    case (ptr)
      8'h00:   rd_byte = reg_ctl;
      8'h01:   rd_byte = reg_lo;
      8'h02:   rd_byte = snap[11:4];
      8'h03:   rd_byte = {snap[3:0], 4'h0};
      default: rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bitcnt      <= 4'd0;
      ack_slot    <= 1'b0;
      mnack       <= 1'b0;
      rx          <= 8'h00;
      tx          <= 8'h00;
      ptr         <= 8'h00;
      reg_ctl     <= 8'h00;
      reg_lo      <= 8'h00;
      snap        <= TEMP_RST;
      sda_oe      <= 1'b0;
      tune_strobe <= 1'b0;
    end else begin
      tune_strobe <= 1'b0;
      if (start_det) begin
        state    <= S_ADDR;
        bitcnt   <= 4'd0;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state    <= S_IDLE;
        ack_slot <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (!ack_slot) begin
            rx     <= {rx[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (state == S_RD) begin
            mnack <= sda_s;
          end
        end else if (scl_fall) begin
          if (ack_slot) begin
            ack_slot <= 1'b0;
            bitcnt   <= 4'd0;
            sda_oe   <= 1'b0;
            if (state == S_RD) begin
              if (mnack) begin
                state <= S_IDLE;
              end else begin
                tx     <= rd_byte;
                ptr    <= ptr + 8'd1;
                sda_oe <= ~rd_byte[7];
              end
            end
          end else if (bitcnt == 4'd8) begin
            ack_slot <= 1'b1;
            case (state)
              S_ADDR: begin
                if (rx[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  state  <= rx[0] ? S_RD : S_PTR;
                  if (!rx[0]) snap <= temp_live;
                end else begin
                  ack_slot <= 1'b0;
                  state    <= S_IDLE;
                end
              end
              S_PTR: begin
                ptr    <= rx;
                snap   <= temp_live;
                sda_oe <= 1'b1;
                state  <= S_WR;
              end
              S_WR: begin
                if (ptr == 8'h00) reg_ctl <= rx;
                if (ptr == 8'h01) begin
                  reg_lo      <= rx;
                  tune_strobe <= 1'b1;
                end
                ptr    <= ptr + 8'd1;
                sda_oe <= 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (state == S_RD) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tune_reg_i2c_chk.sv
module tune_reg_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        stop_det,
  input logic [2:0]  state,
  input logic [7:0]  tune_lo,
  input logic        tune_strobe,
  input logic [11:0] snap
);
  localparam logic [2:0] C_IDLE = 3'd0, C_RD = 3'd4;

  assert_drive_clk_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE) |-> !sda_oe);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tune_strobe |=> !tune_strobe);

  assert_lo_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_lo != $past(tune_lo)) |-> tune_strobe);

  assert_snap_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_RD && $past(state) == C_RD) |-> $stable(snap));
endmodule

bind tune_reg_i2c tune_reg_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .state(state), .tune_lo(reg_lo),
  .tune_strobe(tune_strobe), .snap(snap)
);

// File: tb/tune_reg_i2c_tb.sv
module tune_reg_i2c_tb;
  localparam int Q = 10;
  localparam int NV = 7;
  // {pointer, write data, expected read-back}
  localparam logic [23:0] VECS [0:NV-1] = '{
    24'h00_85_85, 24'h01_3C_3C, 24'h00_7F_7F, 24'h01_FF_FF,
    24'h00_40_40, 24'h07_55_00, 24'h01_01_01
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, comp_hold, tune_strobe;
  logic [11:0] temp_live = 12'h000;
  logic [14:0] tune_word;
  wire  sda_line = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0, strb_cnt = 0;
  bit done = 0;
  bit ack_all;
  logic [7:0] rb [0:3];
  logic [7:0] m0 = 8'h00, m1 = 8'h00;

  always #2.5 clk = ~clk;

  tune_reg_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .temp_live(temp_live), .tune_word(tune_word),
    .comp_hold(comp_hold), .tune_strobe(tune_strobe)
  );

  always @(posedge clk) if (tune_strobe) strb_cnt <= strb_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv(input bit last, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  task automatic wr_bytes(input logic [7:0] p, input logic [7:0] d0,
                          input logic [7:0] d1, input int n);
    bit a;
    ack_all = 1;
    bus_start;
    send(8'h82, a); ack_all &= a;
    send(p, a);     ack_all &= a;
    if (n > 0) begin send(d0, a); ack_all &= a; end
    if (n > 1) begin send(d1, a); ack_all &= a; end
    bus_stop;
  endtask

  task automatic rd_seq(input bit set_ptr, input logic [7:0] p, input int n);
    bit a;
    ack_all = 1;
    bus_start;
    if (set_ptr) begin
      send(8'h82, a); ack_all &= a;
      send(p, a);     ack_all &= a;
      bus_start;
    end
    send(8'h83, a); ack_all &= a;
    for (int i = 0; i < n; i++) recv(i == n - 1, rb[i]);
    chk(sda_oe == 1'b0, "R4 released after NACK", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit a;
    int s0;
    tick(5); rst_n = 1'b1; tick(5);

    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(tune_word == 15'h0, "R5 reset tune_word", tune_word, 0);
    chk(comp_hold == 1'b0, "R5 reset comp_hold", comp_hold, 0);

    // R4 R7 R6: read from reset pointer without word address
    rd_seq(0, 8'h00, 4);
    chk(ack_all, "R1 read address ack", ack_all, 1);
    chk(rb[0] == 8'h00, "R5 reset 00h", rb[0], 8'h00);
    chk(rb[1] == 8'h00, "R5 reset 01h", rb[1], 8'h00);
    chk(rb[2] == 8'h19, "R7 reset temp hi", rb[2], 8'h19);
    chk(rb[3] == 8'h00, "R6 reset temp lo", rb[3], 8'h00);

    // vector table: write one byte, read it back
    for (int v = 0; v < NV; v++) begin
      s0 = strb_cnt;
      wr_bytes(VECS[v][23:16], VECS[v][15:8], 8'h00, 1);
      chk(ack_all, "R3 write acks", ack_all, 1);
      if (VECS[v][23:16] == 8'h00) m0 = VECS[v][15:8];
      if (VECS[v][23:16] == 8'h01) m1 = VECS[v][15:8];
      chk(strb_cnt == s0 + ((VECS[v][23:16] == 8'h01) ? 1 : 0), "R9 strobe count",
          strb_cnt - s0, (VECS[v][23:16] == 8'h01) ? 1 : 0);
      rd_seq(1, VECS[v][23:16], 1);
      chk(rb[0] == VECS[v][7:0], "R3 R8 read-back", rb[0], VECS[v][7:0]);
      chk(tune_word == {m0[6:0], m1}, "R5 tune_word", tune_word, {m0[6:0], m1});
      chk(comp_hold == m0[7], "R5 comp_hold", comp_hold, m0[7]);
    end

    // R3: two bytes with auto-increment
    s0 = strb_cnt;
    wr_bytes(8'h00, 8'h92, 8'h34, 2);
    chk(ack_all, "R3 burst acks", ack_all, 1);
    chk(tune_word == 15'h1234, "R3 burst tune_word", tune_word, 15'h1234);
    chk(comp_hold == 1'b1, "R5 hold bit", comp_hold, 1);
    chk(strb_cnt == s0 + 1, "R9 burst strobe", strb_cnt - s0, 1);

    // R7: snapshot taken at word address, not refreshed by read
    temp_live = 12'hABC;
    ack_all = 1;
    bus_start;
    send(8'h82, a); ack_all &= a;
    send(8'h02, a); ack_all &= a;
    temp_live = 12'h123;
    bus_start;
    send(8'h83, a); ack_all &= a;
    recv(0, rb[0]); recv(1, rb[1]);
    bus_stop;
    chk(ack_all, "R2 repeated start acks", ack_all, 1);
    chk(rb[0] == 8'hAB, "R7 coherent hi", rb[0], 8'hAB);
    chk(rb[1] == 8'hC0, "R6 coherent lo nibble", rb[1], 8'hC0);

    rd_seq(1, 8'h02, 2);
    chk(rb[0] == 8'h12 && rb[1] == 8'h30, "R7 refresh on word address",
        {rb[0], rb[1]}, 16'h1230);

    // R8: read-only registers ignore writes
    wr_bytes(8'h02, 8'hFF, 8'hFF, 2);
    chk(ack_all, "R8 read-only write acked", ack_all, 1);
    rd_seq(1, 8'h02, 2);
    chk(rb[0] == 8'h12 && rb[1] == 8'h30, "R8 read-only unchanged",
        {rb[0], rb[1]}, 16'h1230);

    // R1: foreign address is ignored
    bus_start;
    send(8'hA0, a);
    chk(!a, "R1 foreign address nack", a, 0);
    send(8'h00, a);
    chk(!a, "R1 ignored byte nack", a, 0);
    send(8'h99, a);
    bus_stop;
    chk(tune_word == 15'h1234, "R1 no write after mismatch", tune_word, 15'h1234);

    // R4: auto-increment across the map
    rd_seq(1, 8'h00, 4);
    chk(rb[0] == 8'h92 && rb[1] == 8'h34 && rb[2] == 8'h12 && rb[3] == 8'h30,
        "R4 burst read", {rb[0], rb[1], rb[2], rb[3]}, 32'h92341230);

    // R4: read uses last stored pointer
    wr_bytes(8'h01, 8'h00, 8'h00, 0);
    rd_seq(0, 8'h00, 1);
    chk(rb[0] == 8'h34, "R4 stored pointer", rb[0], 8'h34);
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule